// File: doc/BRIEF.md
# Shift-Capable Integer ALU

This block is the arithmetic and logic unit of a small single-cycle processor. It is purely combinational. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result and a flag that is high when that result is zero. The processor uses the result in one of two ways: as the value written back for arithmetic instructions, or as the byte address for a load or store. The flag drives the branch-on-equal decision, which the processor makes by subtracting the two register values.

Shifts work in a particular way. The value that gets shifted is operand `opA`, which holds the first source register. The shift distance comes from bits 10:6 of operand `opB`. On shift instructions, `opB` carries the sign-extended immediate, and those five bits of it are the instruction's shift-amount field. No other bit of `opB` affects a shift.

Internally, a small decoder turns the operation code into a bundle of one-hot strobes. A datapath then uses those strobes to steer a shared adder, a logic unit and a barrel shifter onto the result.

Top module: `alu_shift_imm`

## Requirements
- R1: Code 0010 gives `result` = `opA` + `opB`, modulo 2^32.
- R2: Code 0110 gives `result` = `opA` − `opB`, modulo 2^32. When the two operands are equal, `zero` is high.
- R3: Code 0000 gives the bitwise AND of the operands. Code 0001 gives their bitwise OR.
- R4: Code 0111 gives 1 when `opA` is less than `opB` as two's-complement signed numbers, and 0 otherwise. This holds even when the difference overflows.
- R5: Code 1000 shifts `opA` left by `opB[10:6]` places and fills the vacated bits with zeros. All other bits of `opB` have no effect.
- R6: Code 1001 shifts `opA` right by `opB[10:6]` places and fills the vacated bits with zeros.
- R7: Code 1010 shifts `opA` right by `opB[10:6]` places and fills the vacated bits with `opA[31]`.
- R8: `zero` is high exactly when all 32 bits of `result` are zero.
- R9: Every code not listed above (0011, 0100, 0101, 1011 to 1111) gives `result` = 0, so `zero` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; the value that is shifted |
| opB | input | 32 | Second operand; bits 10:6 give the shift distance |
| opSel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when `result` is all zeros |

## Verification
Some properties are checked on every input change, because each can be judged from the ports alone:
- the add result matches a subtraction check;
- `zero` follows operand equality when the code is subtract;
- AND never sets a bit that `opA` lacks;
- the set-less-than result only ever occupies bit 0;
- the logical right shift clears the top bit and the arithmetic right shift keeps the sign;
- unused codes return zero.

Exact values need the bench's reference model: shift results at distances 0 and 31, signed comparison across overflow, wrap-around on add, and proof that high `opB` bits do not change a shift.

// File: rtl/alu_shift_imm_pkg.sv
package alu_shift_imm_pkg;

  localparam int DATA_W   = 32;
  localparam int SEL_W    = 4;
  localparam int SHAMT_LO = 6;
  localparam int SHAMT_W  = $clog2(DATA_W);

  typedef enum logic [SEL_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_SHL = 4'b1000,
    OP_SHR = 4'b1001,
    OP_SRA = 4'b1010
  } aluOpE;

  // One-hot steering strobes from the decoder to the datapath
  typedef struct packed {
    logic invB;      // subtract: invert opB and carry in one
    logic selSum;    // adder output
    logic selLess;   // signed less-than bit
    logic selAnd;
    logic selOr;
    logic selShift;  // barrel shifter output
    logic shLeft;    // shift direction
    logic shArith;   // sign fill on right shift
  } aluStrobesT;

endpackage

// File: rtl/alu_shift_imm_ctrl.sv
module alu_shift_imm_ctrl
  import alu_shift_imm_pkg::*;
(
  input  logic [SEL_W-1:0] opSel,
  output aluStrobesT       strobes
);

  always_comb begin
    strobes = '0;
    case (opSel)
      OP_AND: strobes.selAnd = 1'b1;
      OP_OR:  strobes.selOr  = 1'b1;
      OP_ADD: strobes.selSum = 1'b1;
      OP_SUB: begin
        strobes.selSum = 1'b1;
        strobes.invB   = 1'b1;
      end
      OP_SLT: begin
        strobes.selLess = 1'b1;
        strobes.invB    = 1'b1;
      end
      OP_SHL: begin
        strobes.selShift = 1'b1;
        strobes.shLeft   = 1'b1;
      end
      OP_SHR: strobes.selShift = 1'b1;
      OP_SRA: begin
        strobes.selShift = 1'b1;
        strobes.shArith  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu_shift_imm_dp.sv
module alu_shift_imm_dp
  import alu_shift_imm_pkg::*;
#(
  parameter int WIDTH  = DATA_W,
  parameter int AMT_LO = SHAMT_LO,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobesT       strobes,
  output logic [WIDTH-1:0] result
);

  // Shared adder: subtract and compare reuse it with opB inverted
  logic [WIDTH-1:0] bIn;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  logic             lessBit;

  assign bIn     = opB ^ {WIDTH{strobes.invB}};
  assign sum     = opA + bIn + {{(WIDTH-1){1'b0}}, strobes.invB};
  assign ovf     = (opA[WIDTH-1] ^ opB[WIDTH-1]) & (sum[WIDTH-1] ^ opA[WIDTH-1]);
  assign lessBit = sum[WIDTH-1] ^ ovf;

  // Barrel shifter: right shift only; a left shift mirrors the input and the output
  logic [AMT_W-1:0] amt;
  logic             fillBit;
  logic [WIDTH-1:0] shIn;
  logic [WIDTH-1:0] shOut;
  logic [WIDTH-1:0] stageVal [AMT_W+1];

  assign amt     = opB[AMT_LO +: AMT_W];
  assign fillBit = strobes.shArith & opA[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_mirrorIn
    assign shIn[i] = strobes.shLeft ? opA[WIDTH-1-i] : opA[i];
  end

  assign stageVal[0] = shIn;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stageVal[k+1] = amt[k]
      ? {{STEP{fillBit}}, stageVal[k][WIDTH-1:STEP]}
      : stageVal[k];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_mirrorOut
    assign shOut[i] = strobes.shLeft ? stageVal[AMT_W][WIDTH-1-i] : stageVal[AMT_W][i];
  end

  // Result merge: strobes are one-hot, none set yields zero
  always_comb begin
    result = '0;
    if (strobes.selSum)   result |= sum;
    if (strobes.selLess)  result |= {{(WIDTH-1){1'b0}}, lessBit};
    if (strobes.selAnd)   result |= opA & opB;
    if (strobes.selOr)    result |= opA | opB;
    if (strobes.selShift) result |= shOut;
  end

endmodule

// File: rtl/alu_shift_imm.sv
module alu_shift_imm
  import alu_shift_imm_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [3:0]  opSel,
  output logic [31:0] result,
  output logic        zero
);

  aluStrobesT strobes;

  alu_shift_imm_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_shift_imm_dp #(
    .WIDTH  (DATA_W),
    .AMT_LO (SHAMT_LO)
  ) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result)
  );

  assign zero = (result == '0);

endmodule

// File: rtl/alu_shift_imm_chk.sv
module alu_shift_imm_chk (
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [3:0]  opSel,
  input logic [31:0] result,
  input logic        zero
);

  always_comb begin
    if (opSel == 4'b0010)
      AST_ADD_INVERSE : assert ((result - opB) == opA) else $error("add inverse"); // R1
    if (opSel == 4'b0110)
      AST_SUB_EQ_ZERO : assert (zero == (opA == opB)) else $error("sub zero"); // R2
    if (opSel == 4'b0000)
      AST_AND_SUBSET : assert ((result & ~opA) == 32'd0) else $error("and subset"); // R3
    if (opSel == 4'b0111)
      AST_SLT_ONE_BIT : assert (result[31:1] == 31'd0) else $error("slt width"); // R4
    if (opSel == 4'b1000 && opB[10:6] != 5'd0)
      AST_SHL_LSB_CLEAR : assert (result[0] == 1'b0) else $error("shl lsb"); // R5
    if (opSel == 4'b1001 && opB[10:6] != 5'd0)
      AST_SHR_MSB_CLEAR : assert (result[31] == 1'b0) else $error("shr msb"); // R6
    if (opSel == 4'b1010)
      AST_SRA_SIGN_KEPT : assert (result[31] == opA[31]) else $error("sra sign"); // R7
    AST_ZERO_FLAG : assert (zero == (result == 32'd0)) else $error("zero flag"); // R8
    if (opSel inside {4'b0011, 4'b0100, 4'b0101, [4'b1011:4'b1111]})
      AST_UNUSED_ZERO : assert (result == 32'd0 && zero) else $error("unused code"); // R9
  end

endmodule

bind alu_shift_imm alu_shift_imm_chk u_chk (
  .opA    (opA),
  .opB    (opB),
  .opSel  (opSel),
  .result (result),
  .zero   (zero)
);

// File: tb/tb_alu_shift_imm.sv
`timescale 1ns / 1ps
module tb_alu_shift_imm;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = 4'b0011;
  logic [31:0] result;
  logic        zero;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu_shift_imm dut (
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .result (result),
    .zero   (zero)
  );

  function automatic logic [31:0] refResult(logic [31:0] a, logic [31:0] b, logic [3:0] s);
    logic [4:0] sh = b[10:6];
    case (s)
      4'b0000: return a & b;                                 // R3
      4'b0001: return a | b;                                 // R3
      4'b0010: return a + b;                                 // R1
      4'b0110: return a - b;                                 // R2
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R4
      4'b1000: return a << sh;                               // R5
      4'b1001: return a >> sh;                               // R6
      4'b1010: return $unsigned($signed(a) >>> sh);          // R7
      default: return 32'd0;                                 // R9
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] s);
    case (s)
      4'b0010: return "R1";
      4'b0110: return "R2";
      4'b0000, 4'b0001: return "R3";
      4'b0111: return "R4";
      4'b1000: return "R5";
      4'b1001: return "R6";
      4'b1010: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s);
    logic [31:0] expR;
    @(negedge clk);
    opA = a; opB = b; opSel = s;
    #1;
    expR = refResult(a, b, s);
    nChecks++;
    if (result !== expR) begin
      nFails++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", reqOf(s), s, a, b, result, expR);
    end
    nChecks++;
    if (zero !== (expR == 32'd0)) begin
      nFails++;
      $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b", s, a, b, zero, (expR == 32'd0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // reset-like initial state: unused code with zero operands
    #1;
    nChecks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      nFails++;
      $display("FAIL R9 initial result actual=%h/%b expected=0/1", result, zero);
    end
    // R1 wrap-around
    apply(32'hFFFF_FFFF, 32'd1, 4'b0010);
    apply(32'h7FFF_FFFF, 32'd1, 4'b0010);
    // R2 equal operands and borrow
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    apply(32'd0, 32'd1, 4'b0110);
    // R3
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b0000);
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'b0001);
    apply(32'h0, 32'h0, 4'b0001);
    // R4 signed compare, including overflowing differences
    apply(32'hFFFF_FFFF, 32'd1, 4'b0111);
    apply(32'd1, 32'hFFFF_FFFF, 4'b0111);
    apply(32'h8000_0000, 32'd1, 4'b0111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
    apply(32'd5, 32'd5, 4'b0111);
    // R5 R6 R7 distances 0, 1, 31, and high opB bits that must be ignored
    for (int k = 0; k < 3; k++) begin
      logic [31:0] bAmt = {21'h1F_FFFF & {21{k[0]}}, (k == 2) ? 5'd31 : 5'(k), 6'h3F};
      apply(32'h8000_00A5, bAmt, 4'b1000);
      apply(32'h8000_00A5, bAmt, 4'b1001);
      apply(32'h8000_00A5, bAmt, 4'b1010);
      apply(32'h4000_00A5, bAmt, 4'b1010);
    end
    apply(32'hDEAD_BEEF, {21'h0, 5'd4, 6'd0}, 4'b1000);
    apply(32'hDEAD_BEEF, {21'h1A_BCDE, 5'd4, 6'd0}, 4'b1000);
    // R9 every unused code
    foreach (dut.opSel[i]) begin end
    for (int c = 0; c < 16; c++) begin
      if (c inside {3, 4, 5, [11:15]}) apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(c));
    end
    // constrained random, favouring legal codes and occasional equal operands
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom % 8 == 0) ? a : $urandom;
      logic [3:0]  s = ($urandom % 5 == 0) ? 4'($urandom) :
                       4'(({32'h0A98_7621} >> (4 * ($urandom % 8))) & 32'hF);
      apply(a, b, s);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule